// File: doc/BRIEF.md
# Line Power Feed Sequencer

This block is the digital control for the power feed of a small group of subscriber lines. For each line it takes a feed request and the digitized output of that line's current comparator. It drives the line's power-switch enable and a not-acknowledged status flag, which is high whenever a requested feed is not running normally. Three junction-temperature comparator flags (low, middle and high trip points) are shared by all lines. The comparators apply their own hysteresis before the flags reach this block.

When requests arrive together, the block powers the lines one at a time. It picks the lowest-numbered waiting line first. It holds off the next grant for a short settle window and for as long as any powered line still reports high current. A current-flag assertion counts as overcurrent only after it has persisted for a programmable number of clock cycles. Thermal protection works in two stages. At the middle trip point only the lines drawing excess current are dropped. At the high trip point every line is dropped. A dropped line stays off until its request is withdrawn and then raised again.

All asynchronous inputs pass through two-flop synchronizers. Reset clears every line to the unpowered, unrequested state.

Top module: `line_power_seq`

## Requirements
- R1: After reset, every `sw_en_o` bit and every `nack_o` bit is 0.
- R2: While a line's request is low, its `sw_en_o` bit and its `nack_o` bit are both 0.
- R3: A waiting line is powered only while the low, middle and high temperature flags are all clear and no powered line has its current flag set. Until it is powered, its `nack_o` bit is 1.
- R4: Among waiting lines, the lowest index is powered first. At most one line is powered per cycle. After a grant, no further grant is made for `SETTLE` cycles.
- R5: A line's overcurrent indication sets `nack_o` only after its synchronized current flag has been high for `OC_DELAY` consecutive cycles. Any low cycle restarts the count. Overcurrent alone does not remove the feed.
- R6: While the middle temperature flag is set, each powered line whose current flag is set is switched off. Powered lines with a clear current flag stay on.
- R7: While the high temperature flag is set, every powered line is switched off, and every requesting line shows `nack_o` = 1.
- R8: A line switched off by R6 or R7 stays off with `nack_o` = 1 while its request stays high, even after the fault clears. Lowering and then raising the request makes it eligible again.
- R9: With its request high, a line's `nack_o` bit is 0 only when the line is powered, not in qualified overcurrent, and the high temperature flag is clear.
- R10: When a powered line's request falls, its switch turns off at the third rising clock edge. When a line is requested from idle with nothing blocking, its switch turns on at the fourth rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NCH | Per-line feed request, high = feed wanted |
| oc_raw_i | input | NCH | Per-line current-above-indication comparator flag |
| temp_lo_i | input | 1 | Junction temperature above low trip point |
| temp_mid_i | input | 1 | Junction temperature above middle trip point |
| temp_hi_i | input | 1 | Junction temperature above high trip point |
| sw_en_o | output | NCH | Per-line power switch enable |
| nack_o | output | NCH | Per-line not-acknowledged status |

## Verification
Each line's state shows directly on its two outputs, so a corrupted line state shows up within one cycle. Examples are a lost trip latch that re-powers a line without re-arming, or a skipped waiting state that powers a line out of priority order. An error in the grant logic shows up as two enables rising together, or as a higher-index line rising before a lower one, within the settle window. A miscounted overcurrent qualifier shows up as `nack_o` rising one cycle early or late against a count the bench computes, or as a glitch that fails to restart the count.

// File: rtl/line_power_seq.sv
module line_power_seq #(
  parameter int NCH      = 4,
  parameter int OC_DELAY = 2500000,
  parameter int SETTLE   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] oc_raw_i,
  input  logic           temp_lo_i,
  input  logic           temp_mid_i,
  input  logic           temp_hi_i,
  output logic [NCH-1:0] sw_en_o,
  output logic [NCH-1:0] nack_o
);
  localparam int CW = $clog2(OC_DELAY + 1);
  localparam int HW = $clog2(SETTLE + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ON, S_TRIP} line_st_t;

  logic [NCH-1:0] req_m, req_s, oc_m, oc_s;
  logic [2:0]     t_m, t_s;
  line_st_t       st [NCH];
  logic [CW-1:0]  cnt [NCH];
  logic [HW-1:0]  hold;
  logic [NCH-1:0] on_v, wait_v, trip_v, busy_v, oc_q, grant;
  logic           blocked;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_m <= '0; req_s <= '0; oc_m <= '0; oc_s <= '0; t_m <= '0; t_s <= '0;
    end else begin
      req_m <= req_i;  req_s <= req_m;
      oc_m  <= oc_raw_i; oc_s <= oc_m;
      t_m   <= {temp_hi_i, temp_mid_i, temp_lo_i}; t_s <= t_m;
    end

  always_comb
    for (int i = 0; i < NCH; i++) begin
      on_v[i]   = (st[i] == S_ON);
      wait_v[i] = (st[i] == S_WAIT);
      trip_v[i] = (st[i] == S_TRIP);
      busy_v[i] = (st[i] != S_IDLE);
      oc_q[i]   = (cnt[i] == CW'(OC_DELAY));
    end

  assign blocked = (hold != '0) || (|t_s) || (|(on_v & oc_s));

  always_comb begin
    grant = '0;
    if (!blocked)
      for (int i = NCH - 1; i >= 0; i--)
        if (wait_v[i]) grant = NCH'(1) << i;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold <= '0;
    else if (|grant) hold <= HW'(SETTLE);
    else if (hold != '0) hold <= hold - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        st[i]  <= S_IDLE;
        cnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (!oc_s[i]) cnt[i] <= '0;
        else if (!oc_q[i]) cnt[i] <= cnt[i] + 1'b1;
        if (!req_s[i]) st[i] <= S_IDLE;
        else case (st[i])
          S_IDLE: st[i] <= S_WAIT;
          S_WAIT: if (grant[i]) st[i] <= S_ON;
          S_ON:   if (t_s[2] || (t_s[1] && oc_s[i])) st[i] <= S_TRIP;
          default: st[i] <= S_TRIP;
        endcase
      end
    end

  assign sw_en_o = on_v;
  assign nack_o  = busy_v & ~(on_v & ~oc_q & ~{NCH{t_s[2]}});

  p_reset_clear_r1: assert property (@(posedge clk) $rose(rst_n) |-> (sw_en_o == '0 && nack_o == '0));
  p_idle_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(~req_s) & sw_en_o) == '0));
  p_no_grant_hot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (({NCH{$past(t_s[0])}} & sw_en_o & ~$past(sw_en_o)) == '0));
  p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sw_en_o & ~$past(sw_en_o)) <= 1));
  p_oc_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((oc_q & ~$past(oc_q) & ~$past(oc_s)) == '0));
  p_hot_all_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(t_s[2]) || sw_en_o == '0));
  p_trip_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(trip_v & req_s) & ~trip_v) == '0));
endmodule

// File: tb/line_power_seq_tb.sv
module line_power_seq_tb_top;
  localparam int NCH = 4;
  localparam int D   = 10;
  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] req = '0, oc = '0;
  logic t_lo = 0, t_mid = 0, t_hi = 0;
  logic [NCH-1:0] sw, nack;
  int runs = 0, fails = 0;

  always #2 clk = ~clk;

  line_power_seq #(.NCH(NCH), .OC_DELAY(D), .SETTLE(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .oc_raw_i(oc),
    .temp_lo_i(t_lo), .temp_mid_i(t_mid), .temp_hi_i(t_hi),
    .sw_en_o(sw), .nack_o(nack));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 sw", sw, 4'h0); chk("R1 nack", nack, 4'h0);
    rst_n = 1;
    cyc(2);
    chk("R1 sw after release", sw, 4'h0);

    // R2 / R10 per line
    for (int i = 0; i < NCH; i++) begin
      req = 4'(1 << i);
      cyc(3); chk("R10 not yet on", sw, 4'h0);
      cyc(1); chk("R10 on at fourth edge", sw, 4'(1 << i));
      chk("R9 normal nack low", nack, 4'h0);
      req = '0;
      cyc(2); chk("R10 still on", sw, 4'(1 << i));
      cyc(1); chk("R2 off at third edge", sw, 4'h0);
      chk("R2 nack low", nack, 4'h0);
      cyc(6);
    end

    // R4 sweep of all simultaneous request masks
    for (int m = 0; m < 16; m++) begin
      logic [3:0] mk, low;
      mk = 4'(m);
      low = mk & (~mk + 4'd1);
      req = mk;
      cyc(4); chk("R4 lowest first", sw, low);
      cyc(30); chk("R4 all granted", sw, mk); chk("R9 all normal", nack, 4'h0);
      req = '0;
      cyc(4); chk("R2 all released", sw, 4'h0);
      cyc(6);
    end

    // R3 / R4 blocking by powered line in overcurrent, R5 qualification
    req = 4'b0011;
    cyc(4); chk("R4 line0 first", sw, 4'b0001);
    oc = 4'b0001;
    cyc(20);
    chk("R3 line1 held", sw, 4'b0001);
    chk("R5 R3 nack both", nack, 4'b0011);
    oc = '0;
    cyc(12);
    chk("R4 line1 after clear", sw, 4'b0011);
    chk("R9 nack clear", nack, 4'b0000);
    req = '0; cyc(10);

    // R5 exact delay and glitch restart
    req = 4'b0001; cyc(8);
    oc = 4'b0001;
    cyc(D + 1); chk("R5 not yet qualified", nack, 4'b0000);
    cyc(1); chk("R5 qualified", nack, 4'b0001);
    chk("R5 feed kept", sw, 4'b0001);
    oc = '0; cyc(4); chk("R5 cleared", nack, 4'b0000);
    oc = 4'b0001; cyc(8); oc = '0; cyc(1); oc = 4'b0001; cyc(8);
    chk("R5 glitch restarts", nack, 4'b0000);
    oc = '0; req = '0; cyc(10);

    // R3 temperature refusal
    req = 4'b0100; t_lo = 1;
    cyc(10); chk("R3 hot no feed", sw, 4'h0); chk("R3 hot nack", nack, 4'b0100);
    t_lo = 0;
    cyc(5); chk("R3 resumes", sw, 4'b0100); chk("R3 nack clear", nack, 4'h0);
    req = '0; cyc(10);

    // R6 / R8 middle threshold
    req = 4'b0011; cyc(14);
    chk("R6 setup", sw, 4'b0011);
    oc = 4'b0010; t_lo = 1; t_mid = 1;
    cyc(4);
    chk("R6 only limiting line dropped", sw, 4'b0001);
    chk("R6 nack", nack, 4'b0010);
    t_lo = 0; t_mid = 0; oc = '0;
    cyc(10);
    chk("R8 stays off", sw, 4'b0001); chk("R8 nack", nack, 4'b0010);
    req = 4'b0001; cyc(4); req = 4'b0011; cyc(8);
    chk("R8 rearmed", sw, 4'b0011);
    req = '0; cyc(10);

    // R7 / R8 high threshold
    req = 4'hf; cyc(30);
    chk("R7 setup", sw, 4'hf);
    t_lo = 1; t_mid = 1; t_hi = 1;
    cyc(4);
    chk("R7 all off", sw, 4'h0); chk("R7 nack all", nack, 4'hf);
    t_lo = 0; t_mid = 0; t_hi = 0;
    cyc(10);
    chk("R8 all latched", sw, 4'h0); chk("R8 nack latched", nack, 4'hf);
    req = '0; cyc(4);
    chk("R2 nack released", nack, 4'h0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule